// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a free-running event timer. It watches a shared main counter that sits outside the block. When the counter reaches a programmed comparator value, the channel emits a one-cycle interrupt pulse. Software sets it up through a small register window of four 32-bit words: a configuration word, a read-only capability word, and the low and high halves of the comparator.

In one-shot mode the channel fires when the counter equals the comparator. In periodic mode, comparator writes normally program the reload period. A match fires once and then steps the comparator forward by the period until it lies ahead of the counter. "Ahead" is judged by the sign of the difference, so counter wraparound is harmless.

A half-width (32-bit) mode does three things:
- It restricts comparison and arithmetic to the low 32 bits.
- When it is selected, it clears the upper halves of the comparator and the period.
- In one-shot operation, it adds an extra interrupt each time the low 32 counter bits roll over.

Top module: `evt_chan_top`

## Requirements
- R1: After reset the configuration word (regAddr 0) reads 0x30, the capability word (regAddr 1) reads 0x4, both comparator halves (regAddr 2 low, regAddr 3 high) read 0xFFFFFFFF, and irqPulse is low.
- R2: A write to regAddr 0 stores only bits 2 (channel enable), 3 (periodic), 6 (set-value), 8 (half-width) and 13:9 (route). Bits 4 and 5 always read 1, all other bits read 0, and writes to regAddr 1 change nothing.
- R3: A configuration write with bit 1 set (level trigger request) raises levelErr for the following cycle, and bit 1 is not stored.
- R4: In one-shot mode irqPulse is high for exactly the one cycle after the cycle in which counterVal equals the comparator. In full-width mode all 64 bits are compared.
- R5: irqPulse is produced only when both the channel enable bit and globalEn are set.
- R6: Comparator writes are steered by mode. In one-shot mode, or with set-value set, they load the addressed comparator half. In periodic mode a low-half write also loads the period's low half. In periodic mode without set-value, a high-half write loads only the period's high half.
- R7: The set-value bit reads 0 after any write to either comparator half.
- R8: A value loaded into the period has its top bit cleared. For a high-half write that is bit 63. For a low-half write in half-width mode it is bit 31.
- R9: In periodic mode a counter at or past the comparator (signed difference) gives one pulse. The period is then added to the comparator, one addition per cycle, until the comparator is ahead of the counter. No pulse is raised while catching up.
- R10: Writing the configuration with bit 8 set clears the upper 32 bits of comparator and period. In half-width mode matches use only the low 32 bits, and periodic sums are truncated to 32 bits.
- R11: A one-shot channel in half-width mode also pulses when counterVal's low 32 bits step from 0xFFFFFFFF to 0. A full-width channel does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| counterVal | input | 64 | Shared main counter value |
| globalEn | input | 1 | Timer-wide interrupt enable |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Word select: 0 config, 1 capability, 2 comparator low, 3 comparator high |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational while rdEn is high, else 0 |
| irqPulse | output | 1 | One-cycle interrupt pulse |
| levelErr | output | 1 | One-cycle flag for an unsupported level-trigger request |

## Verification
The assertions assume that only one register word is written per cycle. They also assume the counter never sits at or behind the comparator while a periodic channel has a huge period gap, because that would leave the channel catching up for an unbounded number of cycles.

The stimulus holds the counter at values that cannot match while it reprograms the channel. It keeps the random register traffic in one-shot mode with globalEn low, so that no comparator advance races the expected-value model. Counter jumps are used only in the directed catch-up and wraparound cases.

// File: rtl/evt_chan_pkg.sv
package evt_chan_pkg;

  // configuration bit positions
  localparam int CFG_LEVEL  = 1;
  localparam int CFG_EN     = 2;
  localparam int CFG_PER    = 3;
  localparam int CFG_PCAP   = 4;
  localparam int CFG_SCAP   = 5;
  localparam int CFG_SETVAL = 6;
  localparam int CFG_W32    = 8;
  localparam int ROUTE_LO   = 9;
  localparam int ROUTE_HI   = 13;

  localparam logic [31:0] CFG_WR_MASK = 32'h0000_3F4C;
  localparam logic [31:0] CFG_CAPS    = 32'h0000_0030;
  localparam logic [31:0] CFG_HI_WORD = 32'h0000_0004;

  typedef enum logic [1:0] {
    ADDR_CFG_LO = 2'd0,
    ADDR_CFG_HI = 2'd1,
    ADDR_CMP_LO = 2'd2,
    ADDR_CMP_HI = 2'd3
  } regSel_e;

  typedef struct packed {
    logic ldCmpLo;
    logic ldCmpHi;
    logic ldPerLo;
    logic ldPerHi;
    logic trunc32;
    logic rearm;
  } chanStrobe_t;

endpackage

// File: rtl/evt_chan_ctrl.sv
module evt_chan_ctrl
  import evt_chan_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        regAddr,
  input  logic [HALF_W-1:0] wrData,
  output logic [HALF_W-1:0] cfgWord,
  output logic              chEn,
  output logic              periodic,
  output logic              w32,
  output chanStrobe_t       strobe,
  output logic              levelErr
);

  localparam logic [HALF_W-1:0] WR_MASK = HALF_W'(CFG_WR_MASK);
  localparam logic [HALF_W-1:0] CAPS    = HALF_W'(CFG_CAPS);

  logic [HALF_W-1:0] cfgStore;
  logic isCfg, isCmpLo, isCmpHi, setVal;

  assign isCfg   = wrEn && (regAddr == ADDR_CFG_LO);
  assign isCmpLo = wrEn && (regAddr == ADDR_CMP_LO);
  assign isCmpHi = wrEn && (regAddr == ADDR_CMP_HI);

  assign chEn     = cfgStore[CFG_EN];
  assign periodic = cfgStore[CFG_PER];
  assign setVal   = cfgStore[CFG_SETVAL];
  assign w32      = cfgStore[CFG_W32];
  assign cfgWord  = cfgStore | CAPS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgStore <= '0;
      levelErr <= 1'b0;
    end else begin
      levelErr <= isCfg && wrData[CFG_LEVEL];
      if (isCfg) begin
        cfgStore <= wrData & WR_MASK;
      end else if (isCmpLo || isCmpHi) begin
        cfgStore[CFG_SETVAL] <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.ldCmpLo = isCmpLo && (!periodic || setVal);
    strobe.ldPerLo = isCmpLo && periodic;
    strobe.ldCmpHi = isCmpHi && (!periodic || setVal);
    strobe.ldPerHi = isCmpHi && periodic && !setVal;
    strobe.trunc32 = isCfg && wrData[CFG_W32];
    strobe.rearm   = isCfg || isCmpLo || isCmpHi;
  end

  AST_SETVAL_SELFCLR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (regAddr == ADDR_CMP_LO || regAddr == ADDR_CMP_HI)) |=> !cfgWord[CFG_SETVAL]); // R7

  AST_LEVEL_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    levelErr |-> $past(wrEn && regAddr == ADDR_CFG_LO && wrData[CFG_LEVEL])); // R3

endmodule

// File: rtl/evt_chan_dp.sv
module evt_chan_dp
  import evt_chan_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CNT_W-1:0]    counterVal,
  input  logic                globalEn,
  input  logic                chEn,
  input  logic                periodic,
  input  logic                w32,
  input  chanStrobe_t         strobe,
  input  logic [CNT_W/2-1:0]  wrData,
  output logic [CNT_W-1:0]    cmpVal,
  output logic                irqPulse
);

  localparam int HALF_W = CNT_W / 2;

  logic [CNT_W-1:0]  cmpReg, perReg, diffNow, sumFull, nextCmp, diffNext;
  logic [HALF_W-1:0] perLoData, perHiData;
  logic catchUp, prevLoOnes;
  logic reached, aheadNext, eqHit, wrapHit, perFire, oneFire, advance, perZero;

  assign perHiData = {1'b0, wrData[HALF_W-2:0]};
  assign perLoData = w32 ? {1'b0, wrData[HALF_W-2:0]} : wrData;

  assign diffNow   = counterVal - cmpReg;
  assign reached   = w32 ? !diffNow[HALF_W-1] : !diffNow[CNT_W-1];
  assign sumFull   = cmpReg + perReg;
  assign nextCmp   = w32 ? {{HALF_W{1'b0}}, sumFull[HALF_W-1:0]} : sumFull;
  assign diffNext  = counterVal - nextCmp;
  assign aheadNext = w32 ? diffNext[HALF_W-1] : diffNext[CNT_W-1];
  assign perZero   = (perReg == '0);

  assign eqHit   = w32 ? (counterVal[HALF_W-1:0] == cmpReg[HALF_W-1:0])
                       : (counterVal == cmpReg);
  assign wrapHit = w32 && prevLoOnes && (counterVal[HALF_W-1:0] == '0);

  assign perFire = periodic && reached && !catchUp;
  assign oneFire = !periodic && (eqHit || wrapHit);
  assign advance = periodic && !perZero && (perFire || catchUp);

  assign cmpVal = cmpReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpReg     <= '1;
      perReg     <= '0;
      catchUp    <= 1'b0;
      prevLoOnes <= 1'b0;
      irqPulse   <= 1'b0;
    end else begin
      irqPulse   <= (perFire || oneFire) && chEn && globalEn;
      prevLoOnes <= &counterVal[HALF_W-1:0];
      if (strobe.rearm) begin
        catchUp <= 1'b0;
        if (strobe.ldCmpLo) cmpReg[HALF_W-1:0]     <= wrData;
        if (strobe.ldCmpHi) cmpReg[CNT_W-1:HALF_W] <= wrData;
        if (strobe.ldPerLo) perReg[HALF_W-1:0]     <= perLoData;
        if (strobe.ldPerHi) perReg[CNT_W-1:HALF_W] <= perHiData;
        if (strobe.trunc32) begin
          cmpReg[CNT_W-1:HALF_W] <= '0;
          perReg[CNT_W-1:HALF_W] <= '0;
        end
      end else if (!periodic) begin
        catchUp <= 1'b0;
      end else if (perFire || catchUp) begin
        catchUp <= perZero ? 1'b1 : !aheadNext;
        if (advance) cmpReg <= nextCmp;
      end
    end
  end

  AST_PERIOD_MSB: assert property (@(posedge clk) disable iff (!rstN)
    !perReg[CNT_W-1]); // R8

  AST_TRUNC_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.trunc32) |-> (cmpReg[CNT_W-1:HALF_W] == '0 && perReg[CNT_W-1:HALF_W] == '0)); // R10

  AST_CATCHUP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    catchUp |=> !irqPulse); // R9

endmodule

// File: rtl/evt_chan_top.sv
module evt_chan_top
  import evt_chan_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   counterVal,
  input  logic               globalEn,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [1:0]         regAddr,
  input  logic [CNT_W/2-1:0] wrData,
  output logic [CNT_W/2-1:0] rdData,
  output logic               irqPulse,
  output logic               levelErr
);

  localparam int HALF_W = CNT_W / 2;

  logic [HALF_W-1:0] cfgWord;
  logic [CNT_W-1:0]  cmpVal;
  logic chEn, periodic, w32;
  chanStrobe_t strobe;

  evt_chan_ctrl #(.HALF_W(HALF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .cfgWord(cfgWord), .chEn(chEn), .periodic(periodic), .w32(w32),
    .strobe(strobe), .levelErr(levelErr)
  );

  evt_chan_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .counterVal(counterVal), .globalEn(globalEn),
    .chEn(chEn), .periodic(periodic), .w32(w32), .strobe(strobe),
    .wrData(wrData), .cmpVal(cmpVal), .irqPulse(irqPulse)
  );

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (regAddr)
        ADDR_CFG_LO: rdData = cfgWord;
        ADDR_CFG_HI: rdData = HALF_W'(CFG_HI_WORD);
        ADDR_CMP_LO: rdData = cmpVal[HALF_W-1:0];
        default:     rdData = cmpVal[CNT_W-1:HALF_W];
      endcase
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(globalEn)); // R5

endmodule

// File: tb/test_evt_chan_top.sv
module test_evt_chan_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] counterVal;
  logic        globalEn, wrEn, rdEn;
  logic [1:0]  regAddr;
  logic [31:0] wrData, rdData;
  logic        irqPulse, levelErr;

  int nChecks = 0;
  int nFail   = 0;
  logic lastErr;

  always #2 clk = ~clk;

  evt_chan_top i_evt_chan_top (
    .clk(clk), .rstN(rstN), .counterVal(counterVal), .globalEn(globalEn),
    .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .irqPulse(irqPulse), .levelErr(levelErr)
  );

  function automatic logic [31:0] cfgExpect(input logic [31:0] d);
    return (d & 32'h0000_3F4C) | 32'h0000_0030;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    lastErr = levelErr;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rdEn = 1'b1; regAddr = a;
    #1 d = rdData;
    rdEn = 1'b0;
  endtask

  task automatic tick(input logic [63:0] v, output logic irq);
    counterVal = v;
    @(posedge clk); @(negedge clk);
    irq = irqPulse;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [63:0] expCmp;
    logic [31:0] expCfg;
    logic irq;
    int unsigned op;

    void'($urandom(32'd2024));
    rstN = 1'b0; counterVal = '0; globalEn = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    regAddr = '0; wrData = '0; lastErr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    rd(2'd0, d); chk("R1 cfg", d, 32'h30);
    rd(2'd1, d); chk("R1 cap", d, 32'h4);
    rd(2'd2, d); chk("R1 cmp lo", d, 32'hFFFF_FFFF);
    rd(2'd3, d); chk("R1 cmp hi", d, 32'hFFFF_FFFF);
    chk("R1 irq", irqPulse, 1'b0);

    // R2 mask, R10 truncation on half-width select
    wr(2'd0, 32'hFFFF_FFFD);
    rd(2'd0, d); chk("R2 cfg mask", d, 32'h3F7C);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R2 cap read-only", d, 32'h4);
    rd(2'd3, d); chk("R10 cmp hi truncated", d, 32'h0);
    wr(2'd0, 32'h0);
    rd(2'd0, d); chk("R2 cfg cleared", d, 32'h30);

    // R3 level request
    wr(2'd0, 32'h2);
    chk("R3 level flag", lastErr, 1'b1);
    rd(2'd0, d); chk("R3 level not stored", d, 32'h30);
    @(negedge clk);
    chk("R3 flag one cycle", levelErr, 1'b0);

    // random register traffic, one-shot only
    expCmp = 64'h0000_0000_FFFF_FFFF;
    expCfg = 32'h30;
    for (int i = 0; i < 60; i++) begin
      op = $urandom % 3;
      d  = $urandom;
      case (op)
        0: begin
          d[3] = 1'b0;
          wr(2'd0, d);
          chk("R3 level flag random", lastErr, d[1]);
          expCfg = cfgExpect(d);
          if (d[8]) expCmp[63:32] = '0;
        end
        1: begin
          wr(2'd2, d); expCmp[31:0] = d; expCfg[6] = 1'b0;
        end
        default: begin
          wr(2'd3, d); expCmp[63:32] = d; expCfg[6] = 1'b0;
        end
      endcase
      rd(2'd0, d); chk("R7 R2 cfg readback", d, expCfg);
      rd(2'd2, d); chk("R6 cmp lo readback", d, expCmp[31:0]);
      rd(2'd3, d); chk("R6 R10 cmp hi readback", d, expCmp[63:32]);
    end

    // R4 one-shot full width
    globalEn = 1'b1;
    wr(2'd0, 32'h4);
    wr(2'd2, 32'h50);
    wr(2'd3, 32'h1);
    tick(64'h50, irq);          chk("R4 upper bits compared", irq, 1'b0);
    tick(64'h1_0000_004F, irq); chk("R4 before match", irq, 1'b0);
    tick(64'h1_0000_0050, irq); chk("R4 match pulse", irq, 1'b1);
    tick(64'h1_0000_0051, irq); chk("R4 single cycle", irq, 1'b0);

    // R5 enable gating
    globalEn = 1'b0;
    tick(64'h1_0000_0050, irq); chk("R5 global off", irq, 1'b0);
    globalEn = 1'b1;
    tick(64'h0, irq);
    wr(2'd0, 32'h0);
    tick(64'h1_0000_0050, irq); chk("R5 channel off", irq, 1'b0);

    // R10 half-width compare, R11 wrap pulse
    wr(2'd0, 32'h104);
    wr(2'd2, 32'h100);
    tick(64'h7_0000_0100, irq); chk("R10 low-half match", irq, 1'b1);
    tick(64'hFFFF_FFFE, irq);   chk("R11 pre-wrap", irq, 1'b0);
    tick(64'hFFFF_FFFF, irq);   chk("R11 pre-wrap", irq, 1'b0);
    tick(64'h1_0000_0000, irq); chk("R11 wrap pulse", irq, 1'b1);
    tick(64'h1_0000_0001, irq); chk("R11 after wrap", irq, 1'b0);
    wr(2'd0, 32'h4);
    tick(64'hFFFF_FFFF, irq);   chk("R11 full width no wrap", irq, 1'b0);
    tick(64'h1_0000_0000, irq); chk("R11 full width no wrap", irq, 1'b0);
    tick(64'h0, irq);           chk("R4 no match at zero", irq, 1'b0);

    // R6 R7 periodic programming
    wr(2'd0, 32'h4C);
    wr(2'd3, 32'h0);
    rd(2'd0, d); chk("R7 set-value cleared", d, 32'h3C);
    wr(2'd0, 32'h4C);
    wr(2'd2, 32'd100);
    wr(2'd2, 32'd10);
    rd(2'd2, d); chk("R6 periodic write to period only", d, 32'd100);
    wr(2'd3, 32'h0);
    rd(2'd3, d); chk("R6 high write to period only", d, 32'h0);

    // R9 periodic pulses
    for (int v = 90; v <= 125; v++) begin
      tick(64'(v), irq);
      chk("R9 periodic pulse", irq, (v == 100 || v == 110 || v == 120));
    end
    rd(2'd2, d); chk("R9 comparator advanced", d, 32'd130);

    // R9 catch-up after counter jump
    tick(64'd165, irq); chk("R9 catch-up single pulse", irq, 1'b1);
    for (int k = 0; k < 4; k++) begin
      tick(64'd165, irq); chk("R9 quiet while catching up", irq, 1'b0);
    end
    rd(2'd2, d); chk("R9 comparator ahead", d, 32'd170);

    // R8 period top bit, full width
    wr(2'd0, 32'h4C);
    wr(2'd2, 32'h200);
    wr(2'd2, 32'h20);
    wr(2'd3, 32'h8000_0000);
    tick(64'h200, irq); chk("R9 pulse at 0x200", irq, 1'b1);
    rd(2'd3, d); chk("R8 period bit 63 cleared", d, 32'h0);
    rd(2'd2, d); chk("R8 comparator sum", d, 32'h220);

    // R8 R10 half-width periodic across wrap
    wr(2'd0, 32'h0);
    tick(64'hFFFF_FF00, irq);
    wr(2'd0, 32'h14C);
    wr(2'd2, 32'hFFFF_FFF8);
    wr(2'd2, 32'h8000_0010);
    tick(64'hFFFF_FFF8, irq); chk("R10 half-width periodic pulse", irq, 1'b1);
    rd(2'd2, d); chk("R8 R10 truncated sum", d, 32'h8);
    rd(2'd3, d); chk("R10 upper stays zero", d, 32'h0);
    tick(64'h1_0000_0000, irq); chk("R9 no early pulse after wrap", irq, 1'b0);
    tick(64'h1_0000_0008, irq); chk("R9 pulse after wrap", irq, 1'b1);
    rd(2'd2, d); chk("R8 period bit 31 cleared", d, 32'h18);

    summary();
  end

endmodule